// File: doc/BRIEF.md
# LDPC Check Node Processor

This block is one check node of a fully parallel sum-product LDPC decoder. Each cycle it can accept a full set of bit-to-check messages, one per connected edge, and it returns one check-to-bit message per edge. Each returned message is extrinsic: the value sent back on an edge never uses the message that arrived on that same edge.

Incoming messages are 4-bit two's complement numbers with one fractional bit. The node splits each one into a sign and a magnitude. Magnitudes go to the phi domain, phi(x) = ln((e^x+1)/(e^x-1)), through a small quantized table. All phi codes are summed once. Each edge's own code is then taken back out of the total, and the result goes through the same table again, because phi is its own inverse for positive arguments. The signs follow a separate path: each output sign is the XOR of the signs on all the other edges. Results leave in sign-magnitude form.

The data path has one register stage, and each side has a valid/ready handshake. A message set is accepted in any cycle where `in_valid` and `in_ready` are both high. The results appear on `out_msgs` with `out_valid` in the next cycle. While `out_valid` is high and `out_ready` is low, the results stay frozen and `in_ready` is low. A new set can be taken in the same cycle that the previous results are consumed. The degree `DC` is a parameter and defaults to 6.

Top module: `cn_node`

## Requirements
- R1: Input edge k sits in bits [4k+3:4k] of `in_msgs`. Bit 4k+3 is the sign, and the value is the 4-bit two's complement code in units of 0.5. The magnitude is the absolute value of that code, clipped to 7. Code 1000 (-4.0) therefore has magnitude 7.
- R2: The phi table maps a magnitude code m (0..7) to round(2*phi(m/2)), saturated to 7. An m of 0 gives 7. The resulting table is 7,3,2,1,1,0,0,0 for m = 0..7.
- R3: For edge k, the extrinsic sum is the total of all phi codes minus the phi code of edge k. This sum is clipped to 7 and then mapped through the phi table to give the output magnitude in bits [4k+2:4k] of `out_msgs`. The total never overflows for any DC.
- R4: The output sign in bit 4k+3 of `out_msgs` is the XOR of the input signs of every edge except edge k.
- R5: A set accepted at a clock edge is presented on `out_msgs` with `out_valid` high right after that edge. With no new acceptance, `out_valid` drops after an edge where `out_valid` and `out_ready` are both high.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_msgs` stays unchanged. Otherwise `in_ready` is high.
- R7: While `rst_n` is low, `out_valid` is low and `in_ready` is high.
- R8: The degree DC is a parameter (default 6), and R1 to R7 hold for any DC of 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A message set is offered on `in_msgs` |
| in_ready | output | 1 | The node can take a set this cycle |
| in_msgs | input | 4*DC | Bit-to-check messages, edge k in bits [4k+3:4k], two's complement |
| out_valid | output | 1 | `out_msgs` holds a result set |
| out_ready | input | 1 | The downstream side takes the result this cycle |
| out_msgs | output | 4*DC | Check-to-bit messages, edge k in bits [4k+3:4k], sign-magnitude |

## Verification
The bench builds two copies of the node side by side. One has DC = 3, which makes all 4096 input combinations small enough to sweep exhaustively, so every table entry, every clip of the extrinsic sum and every sign pattern is reached. The other uses the default DC = 6 with a hashed sweep of the same length, which exercises wide totals up to 42 and deep sign parities. Directed vectors cover the input code 1000, an extrinsic sum that lands just above the clip, back-pressure stalls and draining.

// File: rtl/cn_pkg.sv
package cn_pkg;
  // Message format: sign bit over a two's complement code with one fractional bit
  localparam int MSG_W   = 4;
  localparam int MAG_W   = MSG_W - 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;

  typedef logic [MAG_W-1:0] mag_t;

  // Quantized phi(x) = ln((e^x+1)/(e^x-1)), x = m/2, output in halves, rounded,
  // saturated at MAG_MAX; m = 0 maps to MAG_MAX.
  function automatic mag_t phi_code(input mag_t m);
    mag_t r;
    case (m)
      3'd0:    r = 3'd7;
      3'd1:    r = 3'd3;
      3'd2:    r = 3'd2;
      3'd3:    r = 3'd1;
      3'd4:    r = 3'd1;
      default: r = 3'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cn_mag_unit.sv
module cn_mag_unit
  import cn_pkg::*;
(
  input  logic [MSG_W-1:0] msg,
  output logic             sgn,
  output mag_t             phi
);
  logic [MSG_W-1:0] absval;
  mag_t             mag;

  always_comb begin
    sgn    = msg[MSG_W-1];
    absval = sgn ? (~msg + 1'b1) : msg;
    // the most negative code has no positive twin: clip it
    if (absval > MSG_W'(MAG_MAX)) mag = mag_t'(MAG_MAX);
    else                          mag = absval[MAG_W-1:0];
    phi = phi_code(mag);
  end
endmodule

// File: rtl/cn_extrinsic.sv
module cn_extrinsic
  import cn_pkg::*;
#(
  parameter int DC = 6
) (
  input  mag_t phi_in  [DC],
  output mag_t mag_out [DC]
);
  localparam int SUM_W = $clog2(DC * MAG_MAX + 1);

  logic [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    for (int k = 0; k < DC; k++) total = total + SUM_W'(phi_in[k]);
  end

  for (genvar k = 0; k < DC; k++) begin : g_edge
    logic [SUM_W-1:0] ext;
    mag_t             ext_clip;
    always_comb begin
      ext = total - SUM_W'(phi_in[k]);
      if (ext > SUM_W'(MAG_MAX)) ext_clip = mag_t'(MAG_MAX);
      else                       ext_clip = ext[MAG_W-1:0];
      mag_out[k] = phi_code(ext_clip);
    end
  end
endmodule

// File: rtl/cn_sign_unit.sv
module cn_sign_unit #(
  parameter int DC = 6
) (
  input  logic [DC-1:0] sgn_in,
  output logic [DC-1:0] sgn_out
);
  logic par;
  assign par = ^sgn_in;

  for (genvar k = 0; k < DC; k++) begin : g_edge
    assign sgn_out[k] = par ^ sgn_in[k];
  end
endmodule

// File: rtl/cn_node.sv
module cn_node
  import cn_pkg::*;
#(
  parameter int DC = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DC*MSG_W-1:0] in_msgs,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DC*MSG_W-1:0] out_msgs
);
  logic [DC*MSG_W-1:0] msg_q;
  logic                vld_q;
  logic                take;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      msg_q <= '0;
    end else begin
      if (take) msg_q <= in_msgs;
      if (take)           vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
    end
  end

  logic [DC-1:0] sgn_in, sgn_out;
  mag_t          phi_v [DC];
  mag_t          mag_v [DC];

  for (genvar k = 0; k < DC; k++) begin : g_front
    cn_mag_unit u_mag (
      .msg (msg_q[k*MSG_W +: MSG_W]),
      .sgn (sgn_in[k]),
      .phi (phi_v[k])
    );
  end

  cn_extrinsic #(.DC(DC)) u_ext (
    .phi_in  (phi_v),
    .mag_out (mag_v)
  );

  cn_sign_unit #(.DC(DC)) u_sgn (
    .sgn_in  (sgn_in),
    .sgn_out (sgn_out)
  );

  for (genvar k = 0; k < DC; k++) begin : g_pack
    assign out_msgs[k*MSG_W +: MSG_W] = {sgn_out[k], mag_v[k]};
  end

  assign out_valid = vld_q;
endmodule

// File: rtl/cn_node_chk.sv
module cn_node_chk
  import cn_pkg::*;
#(
  parameter int DC = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [DC*MSG_W-1:0] in_msgs,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DC*MSG_W-1:0] out_msgs
);
  localparam bit EVEN_DC = (DC % 2) == 0;

  logic in_par, out_par, exp_par;
  always_comb begin
    in_par  = 1'b0;
    out_par = 1'b0;
    for (int k = 0; k < DC; k++) begin
      in_par  = in_par  ^ in_msgs[k*MSG_W + MSG_W-1];
      out_par = out_par ^ out_msgs[k*MSG_W + MSG_W-1];
    end
    exp_par = EVEN_DC ? in_par : 1'b0;
  end

  // R4: the XOR of all output signs follows from the input signs
  assert_sign_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_par == $past(exp_par)));

  // R5: an accepted set is presented in the next cycle
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R5: a consumed result with nothing new behind it leaves
  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R6: a stalled result stays frozen
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msgs)));

  // R6: no acceptance while stalled
  assert_stall_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: reset clears the output side
  assert_reset_R7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind cn_node cn_node_chk #(.DC(DC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_msgs   (in_msgs),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_msgs  (out_msgs)
);

// File: tb/tb_cn_node.sv
module tb_cn_node;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [11:0] in3 = '0;
  logic [23:0] in6 = '0;
  logic        in_ready3, in_ready6, out_valid3, out_valid6;
  logic [11:0] out3;
  logic [23:0] out6;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cn_node #(.DC(3)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready3),
    .in_msgs(in3), .out_valid(out_valid3), .out_ready(out_ready), .out_msgs(out3)
  );

  cn_node #(.DC(6)) dut_w (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready6),
    .in_msgs(in6), .out_valid(out_valid6), .out_ready(out_ready), .out_msgs(out6)
  );

  // R2 reference: quantized phi from the formula
  function automatic int phi_q(input int m);
    real x, p;
    int  q;
    if (m == 0) return 7;
    x = m * 0.5;
    p = $ln(($exp(x) + 1.0) / ($exp(x) - 1.0));
    q = $rtoi(p * 2.0 + 0.5);
    if (q > 7) q = 7;
    return q;
  endfunction

  function automatic logic [23:0] model(input logic [23:0] v, input int dc);
    int ph [6];
    int sg [6];
    int tot, par, e;
    logic [23:0] r;
    logic [3:0]  c;
    int mag;
    tot = 0; par = 0; r = '0;
    for (int k = 0; k < dc; k++) begin
      c = v[4*k +: 4];
      sg[k] = int'(c[3]);
      mag = c[3] ? (16 - int'(c)) : int'(c);   // R1
      if (mag > 7) mag = 7;
      ph[k] = phi_q(mag);
      tot += ph[k];
      par ^= sg[k];
    end
    for (int k = 0; k < dc; k++) begin
      e = tot - ph[k];                          // R3
      if (e > 7) e = 7;
      r[4*k +: 4] = {1'(par ^ sg[k]), 3'(phi_q(e))};
    end
    return r;
  endfunction

  task automatic check_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_vec(input logic [23:0] got, input logic [23:0] exp,
                           input int dc, input string what);
    logic [23:0] sm, mm;
    sm = '0;
    for (int k = 0; k < dc; k++) sm[4*k+3] = 1'b1;
    mm = '0;
    for (int k = 0; k < dc; k++) mm[4*k +: 3] = 3'b111;
    checks++;
    if ((got & sm) !== (exp & sm)) begin
      errors++;
      $display("FAIL R4 sign %s dc=%0d got %h expected %h", what, dc, got, exp);
    end
    checks++;
    if ((got & mm) !== (exp & mm)) begin
      errors++;
      $display("FAIL R2 R3 magnitude %s dc=%0d got %h expected %h", what, dc, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] prev3;
    logic [23:0] prev6;

    // R7: reset state
    #(CLK_PERIOD*2 + 1);
    check_bit(out_valid3, 1'b0, "R7 out_valid");
    check_bit(in_ready3, 1'b1, "R7 in_ready");
    check_bit(out_valid6, 1'b0, "R7 out_valid dc6");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: code 1000 clipped to magnitude 7
    @(negedge clk);
    in_valid = 1'b1; in3 = 12'h228; in6 = '0;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit(out_valid3, 1'b1, "R5 valid after accept");
    check_vec({12'h0, out3}, 24'hAA1, 3, "R1 most negative code");

    // R3: extrinsic sum of 8 must clip to 7
    in_valid = 1'b1; in3 = 12'h330;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec({12'h0, out3}, 24'h002, 3, "R3 clip");
    @(negedge clk);
    check_bit(out_valid3, 1'b0, "R5 drain");

    // R6: back-pressure
    in_valid = 1'b1; in3 = 12'h123; in6 = 24'h9F3A17;
    @(negedge clk);
    out_ready = 1'b0;
    in3 = 12'hF0E; in6 = 24'h0123CD;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check_bit(in_ready3, 1'b0, "R6 in_ready stalled");
      check_bit(out_valid3, 1'b1, "R6 out_valid stalled");
      check_vec({12'h0, out3}, model({12'h0, 12'h123}, 3), 3, "R6 hold");
      check_vec(out6, model(24'h9F3A17, 6), 6, "R6 hold dc6");
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec({12'h0, out3}, model({12'h0, 12'hF0E}, 3), 3, "R6 after release");
    check_vec(out6, model(24'h0123CD, 6), 6, "R6 after release dc6");
    @(negedge clk);

    // R8: exhaustive DC=3 sweep with a hashed DC=6 sweep in lockstep
    prev3 = '0; prev6 = '0;
    for (int i = 0; i <= 4096; i++) begin
      if (i > 0) begin
        check_bit(out_valid3, 1'b1, "R5 streaming valid");
        check_vec({12'h0, out3}, model({12'h0, prev3}, 3), 3, "R8 sweep dc3");
        check_vec(out6, model(prev6, 6), 6, "R8 sweep dc6");
      end
      if (i < 4096) begin
        in_valid = 1'b1;
        in3 = 12'(i);
        in6 = 24'((i * 32'h9E3779B1) >> 5);
        prev3 = in3; prev6 = in6;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    check_bit(out_valid6, 1'b0, "R5 final drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule